// File: doc/BRIEF.md
# Multi-stream payload table update controller

This block is the control and status register unit of a multi-stream display sink. Software writes a pending copy of an eight-word virtual-channel payload allocation table, along with four per-stream payload ID fields and a multi-stream enable. The block then promotes the pending table into an active copy that drives the stream demultiplexer.

There are two ways to promote the table. The first is a self-clearing force bit, which takes effect at once. The second is an update request that software holds high; the block honours it at the first link allocation-change trigger (a one-cycle `act_pulse` input) that arrives after the request was set. A status acknowledge bit reports that this request-based promotion has completed. The bit stays set until software drops the request.

The register port has single-cycle writes and combinational reads. The active table can also be read through its own read-only address window.

Top module: `mst_tbl_ctrl`

## Requirements
- R1: After reset, the control word, the status word, all pending words, all active words, `mst_en`, `stream_ids` and `act_tbl` read as zero.
- R2: The control word at address 0x00 has the following layout. The enable is at bit 0 and the request at bit 30. Stream n's ID sits at bits 4n+7:4n+4, and `stream_ids[4n+3:4n]` outputs it. Bits 31, 29:20 and 3:1 always read as 0.
- R3: A stream ID written with a value from 5 to 15 is stored and output as 0. Values 0 to 4 are kept unchanged.
- R4: The pending words live at addresses 0x02 to 0x09 and can be read and written. The active words are visible at addresses 0x10 to 0x17 and on `act_tbl` (word i at bits 32i+31:32i). Writes to the active window have no effect.
- R5: A control write with bit 31 set copies the pending table into the active table on that write's clock edge. The acknowledge bit is not changed.
- R6: While the request is held and no acknowledge has been given yet, an `act_pulse` copies the pending table into the active table. It also sets the acknowledge bit (status bit 30, address 0x01) on the same edge.
- R7: An `act_pulse` while the request is clear leaves the active table and the acknowledge bit unchanged.
- R8: The acknowledge bit stays 1 while the request is held. It clears on the edge of the control write that drops the request.
- R9: Once the acknowledge bit is set, further `act_pulse` events do not copy the pending table again.
- R10: A control write that sets force and request together updates the active table at once. The acknowledge bit stays 0 until the next `act_pulse`.
- R11: In the status word, every bit other than bit 30 reads 0. Writes to the status address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| act_pulse | input | 1 | One-cycle allocation-change trigger detected on the link |
| mst_en | output | 1 | Multi-stream enable |
| stream_ids | output | 16 | Four 4-bit stream payload IDs, stream 0 in the low nibble |
| act_tbl | output | 256 | Active payload table, word 0 in the low bits |

## Verification
A register write takes effect on the rising edge that samples the strobe. So do a force-triggered promotion and the clearing of the acknowledge bit, and all three are visible in the cycle that follows. A promotion caused by `act_pulse`, and the acknowledge bit it sets, also appear one cycle after the pulse is sampled. Reads have no latency. The bench therefore drives every stimulus on a falling edge and samples outputs and read data on the next falling edge, one register stage later. It checks that nothing changes, as in R4, R7, R9 and R11, at that same point, before the next stimulus is applied.

// File: rtl/mst_tbl_pkg.sv
package mst_tbl_pkg;

    localparam int WORD_W        = 32;
    localparam int TBL_WORDS     = 8;
    localparam int NUM_STREAMS   = 4;
    localparam int ID_W          = 4;
    localparam int MAX_ID        = 4;
    localparam int ADDR_W        = 5;

    localparam int IDX_W         = $clog2(TBL_WORDS);
    localparam int TBL_BITS      = TBL_WORDS * WORD_W;
    localparam int IDS_BITS      = NUM_STREAMS * ID_W;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STAT     = 1;
    localparam int ADDR_SHD_BASE = 2;
    localparam int ADDR_ACT_BASE = 16;

    localparam int BIT_EN        = 0;
    localparam int ID_LSB        = 4;
    localparam int BIT_REQ       = 30;
    localparam int BIT_FORCE     = 31;
    localparam int BIT_ACK       = 30;

    typedef logic [ID_W-1:0]   sid_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [TBL_WORDS-1:0] tbl_t;

    typedef struct packed {
        logic                       req;
        sid_t [NUM_STREAMS-1:0]     ids;
        logic                       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        PR_IDLE = 2'd0,
        PR_WAIT = 2'd1,
        PR_DONE = 2'd2
    } pr_state_t;

    function automatic sid_t clamp_id(input sid_t v);
        return (int'(v) > MAX_ID) ? '0 : v;
    endfunction

    function automatic word_t pack_ctrl(input ctrl_t c);
        word_t w;
        w = '0;
        w[BIT_EN]  = c.en;
        w[BIT_REQ] = c.req;
        for (int s = 0; s < NUM_STREAMS; s++) begin
            w[ID_LSB + s*ID_W +: ID_W] = c.ids[s];
        end
        return w;
    endfunction

endpackage

// File: rtl/mst_ctrl_reg.sv
module mst_ctrl_reg
    import mst_tbl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_ctrl,
    input  word_t  wdata,
    output ctrl_t  ctrl_q,
    output logic   req_next,
    output logic   force_now
);

    ctrl_t ctrl_d;
    logic  unused_ctrl_bits;

    assign unused_ctrl_bits = ^{wdata[BIT_REQ-1:ID_LSB + IDS_BITS], wdata[ID_LSB-1:BIT_EN+1]};

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl) begin
            ctrl_d.en  = wdata[BIT_EN];
            ctrl_d.req = wdata[BIT_REQ];
            for (int s = 0; s < NUM_STREAMS; s++) begin
                ctrl_d.ids[s] = clamp_id(wdata[ID_LSB + s*ID_W +: ID_W]);
            end
        end
    end

    assign req_next  = ctrl_d.req;
    assign force_now = wr_ctrl & wdata[BIT_FORCE];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

endmodule

// File: rtl/mst_promote_ctl.sv
module mst_promote_ctl
    import mst_tbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_next,
    input  logic act_pulse,
    output logic promote,
    output logic ack
);

    pr_state_t state_q, state_d;

    // A request-driven copy happens only in the armed state.
    assign promote = (state_q == PR_WAIT) && act_pulse;
    assign ack     = (state_q == PR_DONE);

    always_comb begin
        state_d = state_q;
        if (!req_next) begin
            state_d = PR_IDLE;
        end else begin
            unique case (state_q)
                PR_IDLE: state_d = PR_WAIT;
                PR_WAIT: if (act_pulse) state_d = PR_DONE;
                PR_DONE: state_d = PR_DONE;
                default: state_d = PR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/mst_tbl_bank.sv
module mst_tbl_bank
    import mst_tbl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shd_we,
    input  logic [IDX_W-1:0] shd_idx,
    input  word_t            wdata,
    input  logic             promote,
    output tbl_t             shd_tbl,
    output tbl_t             act_tbl
);

    word_t shd_r [TBL_WORDS];
    word_t act_r [TBL_WORDS];

    for (genvar i = 0; i < TBL_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                shd_r[i] <= '0;
            end else if (shd_we && (shd_idx == IDX_W'(i))) begin
                shd_r[i] <= wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                act_r[i] <= '0;
            end else if (promote) begin
                act_r[i] <= shd_r[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < TBL_WORDS; i++) begin
            shd_tbl[i] = shd_r[i];
            act_tbl[i] = act_r[i];
        end
    end

endmodule

// File: rtl/mst_tbl_ctrl.sv
module mst_tbl_ctrl
    import mst_tbl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic                 act_pulse,
    output logic                 mst_en,
    output logic [IDS_BITS-1:0]  stream_ids,
    output logic [TBL_BITS-1:0]  act_tbl
);

    ctrl_t            ctrl_q;
    logic             req_next;
    logic             force_now;
    logic             req_q;
    logic             ack_q;
    logic             promote_req;
    logic             promote;
    logic             shd_sel;
    logic             act_sel;
    logic [IDX_W-1:0] shd_idx;
    logic [IDX_W-1:0] act_idx;
    tbl_t             shd_tbl;
    tbl_t             act_words;
    logic [TBL_BITS-1:0] shd_flat;

    assign shd_sel = (int'(reg_addr) >= ADDR_SHD_BASE) &&
                     (int'(reg_addr) <  ADDR_SHD_BASE + TBL_WORDS);
    assign act_sel = (int'(reg_addr) >= ADDR_ACT_BASE) &&
                     (int'(reg_addr) <  ADDR_ACT_BASE + TBL_WORDS);
    assign shd_idx = IDX_W'(int'(reg_addr) - ADDR_SHD_BASE);
    assign act_idx = IDX_W'(int'(reg_addr) - ADDR_ACT_BASE);

    mst_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (reg_wr && (int'(reg_addr) == ADDR_CTRL)),
        .wdata     (reg_wdata),
        .ctrl_q    (ctrl_q),
        .req_next  (req_next),
        .force_now (force_now)
    );

    mst_promote_ctl u_prom (
        .clk       (clk),
        .rst       (rst),
        .req_next  (req_next),
        .act_pulse (act_pulse),
        .promote   (promote_req),
        .ack       (ack_q)
    );

    assign promote = force_now | promote_req;

    mst_tbl_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .shd_we  (reg_wr && shd_sel),
        .shd_idx (shd_idx),
        .wdata   (reg_wdata),
        .promote (promote),
        .shd_tbl (shd_tbl),
        .act_tbl (act_words)
    );

    assign req_q      = ctrl_q.req;
    assign mst_en     = ctrl_q.en;
    assign stream_ids = ctrl_q.ids;
    assign act_tbl    = act_words;
    assign shd_flat   = shd_tbl;

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) == ADDR_CTRL) begin
            reg_rdata = pack_ctrl(ctrl_q);
        end else if (int'(reg_addr) == ADDR_STAT) begin
            reg_rdata[BIT_ACK] = ack_q;
        end else if (shd_sel) begin
            reg_rdata = shd_tbl[shd_idx];
        end else if (act_sel) begin
            reg_rdata = act_words[act_idx];
        end
    end

endmodule

// File: rtl/mst_tbl_ctrl_chk.sv
module mst_tbl_ctrl_chk
    import mst_tbl_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                act_pulse,
    input logic                req_q,
    input logic                ack_q,
    input logic                force_now,
    input logic [IDS_BITS-1:0] stream_ids,
    input logic [TBL_BITS-1:0] act_tbl,
    input logic [TBL_BITS-1:0] shd_flat
);

    p_ack_needs_req_r8: assert property (@(posedge clk) disable iff (rst)
        ack_q |-> req_q);

    p_ack_rise_act_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(act_pulse));

    p_ack_copy_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> (act_tbl == $past(shd_flat)));

    p_force_copy_r5: assert property (@(posedge clk) disable iff (rst)
        force_now |=> (act_tbl == $past(shd_flat)));

    p_idle_act_r7: assert property (@(posedge clk) disable iff (rst)
        (act_pulse && !req_q && !force_now) |=> $stable(act_tbl));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (act_pulse && ack_q && !force_now) |=> $stable(act_tbl));

    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_id
        p_id_legal_r3: assert property (@(posedge clk) disable iff (rst)
            int'(stream_ids[s*ID_W +: ID_W]) <= MAX_ID);
    end

endmodule

bind mst_tbl_ctrl mst_tbl_ctrl_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .act_pulse  (act_pulse),
    .req_q      (req_q),
    .ack_q      (ack_q),
    .force_now  (force_now),
    .stream_ids (stream_ids),
    .act_tbl    (act_tbl),
    .shd_flat   (shd_flat)
);

// File: tb/mst_tbl_ctrl_tb_top.sv
module mst_tbl_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         reg_wr = 1'b0;
    logic [4:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         act_pulse = 1'b0;
    logic         mst_en;
    logic [15:0]  stream_ids;
    logic [255:0] act_tbl;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    logic [31:0] exp_shd [8];
    logic [31:0] exp_act [8];

    always #5 clk = ~clk;

    mst_tbl_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .act_pulse  (act_pulse),
        .mst_en     (mst_en),
        .stream_ids (stream_ids),
        .act_tbl    (act_tbl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic pulse_act();
        @(negedge clk);
        act_pulse = 1'b1;
        @(negedge clk);
        act_pulse = 1'b0;
    endtask

    task automatic check_active(input string tag);
        for (int i = 0; i < 8; i++) begin
            chk(tag, act_tbl[i*32 +: 32], exp_act[i]);
            rd_chk(tag, 5'(16 + i), exp_act[i]);
        end
    endtask

    task automatic load_shadow(input logic [15:0] seed);
        for (int i = 0; i < 8; i++) begin
            exp_shd[i] = {seed, 8'(i), 8'(i * 3 + 1)};
            wr(5'(2 + i), exp_shd[i]);
        end
    endtask

    task automatic t_reset();
        rd_chk("R1 ctrl", 5'd0, 32'h0);
        rd_chk("R1 status", 5'd1, 32'h0);
        for (int i = 0; i < 8; i++) begin
            rd_chk("R1 pending", 5'(2 + i), 32'h0);
            exp_act[i] = '0;
            exp_shd[i] = '0;
        end
        check_active("R1 active");
        chk("R1 mst_en", {31'b0, mst_en}, 32'h0);
        chk("R1 stream_ids", {16'b0, stream_ids}, 32'h0);
    endtask

    task automatic t_ctrl_layout();
        wr(5'd0, 32'h3FF4_321F);
        rd_chk("R2 ctrl readback", 5'd0, 32'h0004_3211);
        chk("R2 mst_en", {31'b0, mst_en}, 32'h1);
        chk("R2 stream_ids", {16'b0, stream_ids}, 32'h4321);
    endtask

    task automatic t_clamp();
        wr(5'd0, 32'h0009_4F50);
        chk("R3 stream_ids clamp", {16'b0, stream_ids}, 32'h0400);
        rd_chk("R3 ctrl clamp", 5'd0, 32'h0000_4000);
    endtask

    task automatic t_windows();
        load_shadow(16'hA5C3);
        for (int i = 0; i < 8; i++) rd_chk("R4 pending rw", 5'(2 + i), exp_shd[i]);
        wr(5'd16, 32'hDEAD_BEEF);
        wr(5'd23, 32'hFFFF_FFFF);
        check_active("R4 active window read-only");
    endtask

    task automatic t_idle_act();
        wr(5'd0, 32'h0000_0001);
        pulse_act();
        check_active("R7 act without request");
        rd_chk("R7 status", 5'd1, 32'h0);
    endtask

    task automatic t_force();
        wr(5'd0, 32'h8000_0001);
        for (int i = 0; i < 8; i++) exp_act[i] = exp_shd[i];
        check_active("R5 force copy");
        rd_chk("R5 force bit reads 0", 5'd0, 32'h0000_0001);
        rd_chk("R5 status untouched", 5'd1, 32'h0);
    endtask

    task automatic t_request();
        load_shadow(16'h1234);
        wr(5'd0, 32'h4000_0001);
        check_active("R6 no copy before act");
        rd_chk("R6 status before act", 5'd1, 32'h0);
        pulse_act();
        for (int i = 0; i < 8; i++) exp_act[i] = exp_shd[i];
        check_active("R6 copy on act");
        rd_chk("R6 ack set", 5'd1, 32'h4000_0000);
    endtask

    task automatic t_after_ack();
        exp_shd[0] = 32'h0BAD_F00D;
        wr(5'd2, exp_shd[0]);
        pulse_act();
        check_active("R9 no second copy");
        rd_chk("R8 ack held with request", 5'd1, 32'h4000_0000);
        wr(5'd0, 32'h0000_0001);
        rd_chk("R8 ack cleared", 5'd1, 32'h0);
    endtask

    task automatic t_force_and_req();
        load_shadow(16'h7E01);
        wr(5'd0, 32'hC000_0001);
        for (int i = 0; i < 8; i++) exp_act[i] = exp_shd[i];
        check_active("R10 force wins");
        rd_chk("R10 ack waits", 5'd1, 32'h0);
        pulse_act();
        rd_chk("R10 ack after act", 5'd1, 32'h4000_0000);
    endtask

    task automatic t_status();
        wr(5'd1, 32'hFFFF_FFFF);
        rd_chk("R11 status write ignored", 5'd1, 32'h4000_0000);
        wr(5'd0, 32'h0000_0000);
        wr(5'd1, 32'hFFFF_FFFF);
        rd_chk("R11 status stays zero", 5'd1, 32'h0);
        rd_chk("R11 ctrl unaffected", 5'd0, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ctrl_layout();
        t_clamp();
        t_windows();
        t_idle_act();
        t_force();
        t_request();
        t_after_ack();
        t_force_and_req();
        t_status();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule